// File: doc/BRIEF.md
# Deskew Training Pattern Framer

This block sits on the transmit side of a parallel-to-serial link, just ahead of a 7:1 serializer. On every clock it produces one 7-slot frame for a clock lane and one 7-slot frame for each of several data lanes. In normal operation each data lane carries the encoded word presented for it, and the clock lane carries the regular clock shape.

While the active-low training request is held low, the block stops taking in its lane words. Every data lane then carries a fixed, clock-like training shape. The clock lane switches to a different shape that tells the receiver training is under way, so the receiver can align its sampling strobes. The mode is registered, so a frame is never split between the two modes.

A controller with three states governs the mode:
- `ST_NORMAL` moves to `ST_TRAINING` on the first low sample of the request.
- `ST_TRAINING` moves to `ST_TRAINED` once `MIN_TRAIN` consecutive low samples have been seen. If the request is sampled high before that, it returns to `ST_NORMAL` and sets a sticky short-training flag.
- `ST_TRAINED` returns to `ST_NORMAL` when the request is sampled high.

Each of the three shapes has two variants. A parameter fixed at elaboration picks the variant for each shape.

Top module: `dsk_train_framer`

## Requirements
- R1: After reset, the clock lane shows the normal clock shape, every data lane is 0000000, and the short-training flag is 0.
- R2: When the request is sampled high at a rising edge, lane i of `data_lanes_o` (bits 7i+6 down to 7i, bit 7i+6 being the first slot) equals lane i of `lane_words_i` sampled at that edge, from that edge until the next.
- R3: In normal mode the clock lane is 1111000, or 1110000 when `NORM_CLK_ALT` is 1 (bit 6 is the first slot).
- R4: From the edge that first samples the request low until the edge that samples it high, the clock lane is 1111100, or 1100000 when `TRAIN_CLK_ALT` is 1.
- R5: During that same window, every data lane is 1111000, or 1110000 when `TRAIN_DATA_ALT` is 1.
- R6: Lane words presented while the request is low are never captured. After return to normal, each lane shows the word sampled at the returning edge.
- R7: A low run of fewer than `MIN_TRAIN` (default 4) consecutive samples sets `train_short_o` at the edge that samples the request high. A run of `MIN_TRAIN` or more leaves the flag unchanged.
- R8: Once set, `train_short_o` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| train_req_n | input | 1 | Training request, active low |
| lane_words_i | input | 7*N_LANES | Encoded words, 7 bits per lane |
| clk_lane_o | output | 7 | Clock lane frame, bit 6 first |
| data_lanes_o | output | 7*N_LANES | Data lane frames, 7 bits per lane |
| train_short_o | output | 1 | Sticky flag: a training run was too short |

## Verification
The assertions take for granted that `train_req_n` and `lane_words_i` carry known values and are stable around each rising edge. They also assume the variant choices do not change after elaboration.

The stimulus meets these assumptions by driving every input at the falling edge with defined values. It holds the request low for runs of 1, 3, exactly 4 and 6 cycles, changes the lane words freely inside each run, and applies a reset mid-run so the sticky flag can be exercised twice. A second instance built with every alternate variant receives the same stimulus.

// File: rtl/dsk_pkg.sv
package dsk_pkg;

    localparam int SLOTS = 7;

    typedef logic [SLOTS-1:0] frame_t;

    typedef enum logic [1:0] {
        ST_NORMAL   = 2'd0,
        ST_TRAINING = 2'd1,
        ST_TRAINED  = 2'd2
    } dsk_state_e;

    localparam frame_t NORM_CLK_A  = 7'b1111000;
    localparam frame_t NORM_CLK_B  = 7'b1110000;
    localparam frame_t TRAIN_CLK_A = 7'b1111100;
    localparam frame_t TRAIN_CLK_B = 7'b1100000;
    localparam frame_t TRAIN_DAT_A = 7'b1111000;
    localparam frame_t TRAIN_DAT_B = 7'b1110000;

    function automatic frame_t pick(input bit alt, input frame_t a, input frame_t b);
        return alt ? b : a;
    endfunction

endpackage

// File: rtl/dsk_mode_fsm.sv
module dsk_mode_fsm
    import dsk_pkg::*;
#(
    parameter int MIN_TRAIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    output logic train_o,
    output logic short_o
);

    localparam int CW = $clog2(MIN_TRAIN + 1);
    localparam logic [CW-1:0] MIN_C = CW'(MIN_TRAIN);
    localparam bit ONE_ENOUGH = (MIN_TRAIN <= 1);

    dsk_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          short_q, short_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        short_d = short_q;
        unique case (state_q)
            ST_NORMAL: begin
                if (!req_n) begin
                    cnt_d   = CW'(1);
                    state_d = ONE_ENOUGH ? ST_TRAINED : ST_TRAINING;
                end
            end
            ST_TRAINING: begin
                if (req_n) begin
                    short_d = 1'b1;
                    cnt_d   = '0;
                    state_d = ST_NORMAL;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                    if (cnt_q + CW'(1) == MIN_C) begin
                        state_d = ST_TRAINED;
                    end
                end
            end
            ST_TRAINED: begin
                if (req_n) begin
                    cnt_d   = '0;
                    state_d = ST_NORMAL;
                end
            end
            default: begin
                state_d = ST_NORMAL;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_NORMAL;
            cnt_q   <= '0;
            short_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            short_q <= short_d;
        end
    end

    always_comb begin
        train_o = (state_q != ST_NORMAL);
        short_o = short_q;
    end

    // R7
    short_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(short_o) |-> ($past(state_q == ST_TRAINING) && $past(req_n)));

    // R8
    short_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        short_o |=> short_o);

endmodule

// File: rtl/dsk_lane_slot.sv
module dsk_lane_slot
    import dsk_pkg::*;
#(
    parameter frame_t TRAIN_PAT = TRAIN_DAT_A
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   take_i,
    input  logic   train_i,
    input  frame_t word_i,
    output frame_t pat_o
);

    frame_t word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (take_i) begin
            word_q <= word_i;
        end
    end

    always_comb begin
        pat_o = train_i ? TRAIN_PAT : word_q;
    end

    // R2
    pass_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(take_i)) |-> (pat_o == $past(word_i)));

    // R5
    train_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(take_i)) |-> (pat_o == TRAIN_PAT));

endmodule

// File: rtl/dsk_train_framer.sv
module dsk_train_framer
    import dsk_pkg::*;
#(
    parameter int N_LANES        = 8,
    parameter int MIN_TRAIN      = 4,
    parameter bit NORM_CLK_ALT   = 1'b0,
    parameter bit TRAIN_CLK_ALT  = 1'b0,
    parameter bit TRAIN_DATA_ALT = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       train_req_n,
    input  logic [N_LANES*SLOTS-1:0]   lane_words_i,
    output logic [SLOTS-1:0]           clk_lane_o,
    output logic [N_LANES*SLOTS-1:0]   data_lanes_o,
    output logic                       train_short_o
);

    localparam frame_t NORM_CLK  = pick(NORM_CLK_ALT,   NORM_CLK_A,  NORM_CLK_B);
    localparam frame_t TRAIN_CLK = pick(TRAIN_CLK_ALT,  TRAIN_CLK_A, TRAIN_CLK_B);
    localparam frame_t TRAIN_DAT = pick(TRAIN_DATA_ALT, TRAIN_DAT_A, TRAIN_DAT_B);

    logic train;

    dsk_mode_fsm #(
        .MIN_TRAIN (MIN_TRAIN)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_n   (train_req_n),
        .train_o (train),
        .short_o (train_short_o)
    );

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        dsk_lane_slot #(
            .TRAIN_PAT (TRAIN_DAT)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .take_i  (train_req_n),
            .train_i (train),
            .word_i  (lane_words_i[g*SLOTS +: SLOTS]),
            .pat_o   (data_lanes_o[g*SLOTS +: SLOTS])
        );
    end

    always_comb begin
        clk_lane_o = train ? TRAIN_CLK : NORM_CLK;
    end

    // R3
    norm_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(train_req_n)) |-> (clk_lane_o == NORM_CLK));

    // R4
    train_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(train_req_n)) |-> (clk_lane_o == TRAIN_CLK));

endmodule

// File: tb/tb_dsk_train_framer.sv
module tb_dsk_train_framer;

    localparam int CLK_PERIOD = 10;
    localparam int NL  = 8;
    localparam int MIN = 4;
    localparam int W   = NL * 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_n = 1'b1;
    logic [W-1:0] words = '0;
    logic [6:0]   clk_a, clk_b;
    logic [W-1:0] dat_a, dat_b;
    logic         err_a, err_b;

    int vectors = 0;
    int miscompares = 0;

    // behavioural reference state
    bit         m_train = 1'b0;
    bit         m_prev_train = 1'b0;
    bit         m_err = 1'b0;
    bit         m_prev_err = 1'b0;
    int         m_low = 0;
    logic [6:0] m_word [NL];

    always #(CLK_PERIOD/2) clk = ~clk;

    dsk_train_framer #(.N_LANES(NL), .MIN_TRAIN(MIN)) dut (
        .clk(clk), .rst_n(rst_n), .train_req_n(req_n), .lane_words_i(words),
        .clk_lane_o(clk_a), .data_lanes_o(dat_a), .train_short_o(err_a));

    dsk_train_framer #(.N_LANES(NL), .MIN_TRAIN(MIN), .NORM_CLK_ALT(1'b1),
                       .TRAIN_CLK_ALT(1'b1), .TRAIN_DATA_ALT(1'b1)) dut_alt (
        .clk(clk), .rst_n(rst_n), .train_req_n(req_n), .lane_words_i(words),
        .clk_lane_o(clk_b), .data_lanes_o(dat_b), .train_short_o(err_b));

    function automatic logic [6:0] exp_clk(input bit alt, input bit trn);
        if (trn) return alt ? 7'b1100000 : 7'b1111100;
        return alt ? 7'b1110000 : 7'b1111000;
    endfunction

    function automatic logic [6:0] exp_lane(input bit alt, input bit trn, input logic [6:0] w);
        if (trn) return alt ? 7'b1110000 : 7'b1111000;
        return w;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string ctag, dtag, etag;
        logic [W-1:0] ea, eb;
        ctag = m_train ? "R4 clock lane" : "R3 clock lane";
        if (m_train) dtag = "R5 data lanes";
        else if (m_prev_train) dtag = "R6 data lanes";
        else dtag = "R2 data lanes";
        etag = (m_err != m_prev_err) ? "R7 short flag" : "R8 short flag";
        for (int i = 0; i < NL; i++) begin
            ea[i*7 +: 7] = exp_lane(1'b0, m_train, m_word[i]);
            eb[i*7 +: 7] = exp_lane(1'b1, m_train, m_word[i]);
        end
        check(ctag, W'(clk_a), W'(exp_clk(1'b0, m_train)));
        check({ctag, " alt"}, W'(clk_b), W'(exp_clk(1'b1, m_train)));
        check(dtag, dat_a, ea);
        check({dtag, " alt"}, dat_b, eb);
        check(etag, W'(err_a), W'(m_err));
        check({etag, " alt"}, W'(err_b), W'(m_err));
    endtask

    // one frame: drive at falling edge, advance model at rising edge, compare at next falling edge
    task automatic step(input bit rq, input bit rst_v);
        for (int i = 0; i < NL; i++) words[i*7 +: 7] = 7'($urandom);
        req_n = rq;
        rst_n = rst_v;
        @(posedge clk);
        m_prev_train = m_train;
        m_prev_err   = m_err;
        if (!rst_n) begin
            m_train = 1'b0; m_err = 1'b0; m_low = 0;
            for (int i = 0; i < NL; i++) m_word[i] = '0;
        end else if (req_n) begin
            if (m_train && m_low < MIN) m_err = 1'b1;
            m_train = 1'b0;
            m_low = 0;
            for (int i = 0; i < NL; i++) m_word[i] = words[i*7 +: 7];
        end else begin
            m_train = 1'b1;
            if (m_low < MIN) m_low++;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic run(input bit rq, input int n);
        for (int k = 0; k < n; k++) step(rq, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < NL; i++) m_word[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        compare_all();
        run(1'b1, 12);        // R2 R3 normal traffic
        run(1'b0, 4);         // exact minimum, R4 R5
        run(1'b1, 5);         // R6 return, no flag
        run(1'b0, 6);         // long run, inputs change inside, R6
        run(1'b1, 3);
        run(1'b0, 3);         // R7 short run
        run(1'b1, 4);
        run(1'b0, 6);         // R8 stays set
        run(1'b1, 3);
        step(1'b1, 1'b0);     // reset mid-run, R1
        step(1'b1, 1'b0);
        run(1'b1, 3);
        run(1'b0, 1);         // R7 single-cycle request
        run(1'b1, 2);
        run(1'b0, 5);
        step(1'b1, 1'b1);
        run(1'b0, 2);
        run(1'b1, 6);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule